// File: doc/BRIEF.md
# Burst Address Counter

This block generates the internal access address for one port of a synchronous memory. Three active-low controls pick one of four actions: clear to zero, load the external address, step by one, or keep the last address. They are applied in a fixed priority. The chosen address goes out combinationally on `acc_addr`. The memory array samples it at the same rising edge that samples write data and read/write controls. Because of this there is no dead cycle between a load, clear or step and the access that uses it.

At each rising edge `acc_addr` is also captured into a register and presented as `last_addr`. That register is the base for the next step or hold. Chip enables and byte selects play no part here: the address path moves whether or not an access takes place. The width is a parameter, 15 bits by default and 14 for the half-depth array.

Top module: `burst_addr_ctr`

## Requirements
- R1: While `rst_n` is low at a rising edge, `last_addr` becomes 0, whatever the other inputs are.
- R2: With `clear_n` low, `acc_addr` is 0 whatever `strobe_n`, `step_n` and `ext_addr` are, and `last_addr` is 0 after the edge.
- R3: With `clear_n` high and `strobe_n` low, `acc_addr` equals `ext_addr`, whatever `step_n` is.
- R4: With `clear_n` and `strobe_n` high and `step_n` low, `acc_addr` equals `last_addr` plus one.
- R5: With all three controls high, `acc_addr` equals `last_addr`, and `last_addr` keeps its value across the edge.
- R6: Stepping from the highest address (all ones) gives address 0.
- R7: After each rising edge with `rst_n` high, `last_addr` equals the value `acc_addr` had just before that edge.
- R8: Changes on the controls or `ext_addr` between rising edges leave `last_addr` unchanged. Only values present at an edge are used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the held address |
| ext_addr | input | ADDR_W | Address offered from outside |
| strobe_n | input | 1 | Active-low load of `ext_addr` |
| step_n | input | 1 | Active-low advance by one |
| clear_n | input | 1 | Active-low clear to address 0, highest priority |
| acc_addr | output | ADDR_W | Address for the access taken at the coming edge |
| last_addr | output | ADDR_W | Registered address of the previous access |

## Verification
The bench drives conflicting controls together. A clear is combined with a load and a step, and a load is combined with a step. A design with the wrong priority would show the external or stepped address where 0 or the loaded value is due. A step from all ones checks the wrap: a design with a wide or saturating adder would stick at the top or leave stray bits. Pulses on the strobe between edges check that nothing is taken in asynchronously; a latch-style load would disturb `last_addr`. Each cycle compares `last_addr` with the address presented before the edge, which exposes a dead cycle or a one-cycle lag.

// File: rtl/bac_pkg.sv
// Shared types for the burst address counter.
// Assumes: nothing beyond IEEE 1800-2017.
package bac_pkg;
    // Action chosen for one clock cycle, decoded by priority.
    typedef enum logic [1:0] {
        BAC_KEEP  = 2'd0,
        BAC_STEP  = 2'd1,
        BAC_LOAD  = 2'd2,
        BAC_CLEAR = 2'd3
    } bac_op_e;
endpackage

// File: rtl/bac_decode.sv
// Priority decoder: clear over load over step over keep.
// Assumes: all controls are active low and already synchronous to the clock.
module bac_decode
    import bac_pkg::*;
(
    input  logic    strobe_n,
    input  logic    step_n,
    input  logic    clear_n,
    output bac_op_e op
);
    // Pick one action per cycle, highest priority first.
    always_comb begin
        if (!clear_n) begin
            op = BAC_CLEAR;
        end else if (!strobe_n) begin
            op = BAC_LOAD;
        end else if (!step_n) begin
            op = BAC_STEP;
        end else begin
            op = BAC_KEEP;
        end
    end
endmodule

// File: rtl/bac_select.sv
// Forms this cycle's address from the decoded action.
// Assumes: the increment wraps modulo 2**ADDR_W.
module bac_select
    import bac_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  bac_op_e           op,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] sel_addr
);
    localparam logic [ADDR_W-1:0] ZERO_ADDR = '0;
    localparam logic [ADDR_W-1:0] ONE_STEP  = ADDR_W'(1);

    logic [ADDR_W-1:0] stepped;

    // Modulo increment; carry out of the top bit is dropped on purpose.
    always_comb begin
        stepped = base_addr + ONE_STEP;
    end

    // Route the chosen source to the output.
    always_comb begin
        unique case (op)
            BAC_CLEAR: sel_addr = ZERO_ADDR;
            BAC_LOAD:  sel_addr = ext_addr;
            BAC_STEP:  sel_addr = stepped;
            default:   sel_addr = base_addr;
        endcase
    end
endmodule

// File: rtl/bac_hold_reg.sv
// Holds the address used by the previous access.
// Assumes: synchronous active-low reset clears to zero.
module bac_hold_reg #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);
    // Capture this cycle's address at the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/burst_addr_ctr.sv
// Per-port burst address counter. It presents the access address for the
// coming edge and keeps the last used address as the base for the next step.
// Assumes: the memory samples acc_addr on the same rising edge.
module burst_addr_ctr
    import bac_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_n,
    input  logic              step_n,
    input  logic              clear_n,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] last_addr
);
    bac_op_e           op;
    logic [ADDR_W-1:0] sel_addr;
    logic [ADDR_W-1:0] held_addr;

    bac_decode u_decode (
        .strobe_n (strobe_n),
        .step_n   (step_n),
        .clear_n  (clear_n),
        .op       (op)
    );

    bac_select #(.ADDR_W(ADDR_W)) u_select (
        .op        (op),
        .ext_addr  (ext_addr),
        .base_addr (held_addr),
        .sel_addr  (sel_addr)
    );

    bac_hold_reg #(.ADDR_W(ADDR_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sel_addr),
        .q     (held_addr)
    );

    // Drive the ports from the internal nets.
    always_comb begin
        acc_addr  = sel_addr;
        last_addr = held_addr;
    end
endmodule

// File: rtl/bac_checker.sv
// Port-level properties of the burst address counter, bound to every instance.
// Assumes: rst_n is the only reset.
module bac_checker #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              strobe_n,
    input logic              step_n,
    input logic              clear_n,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [ADDR_W-1:0] last_addr
);
    localparam logic [ADDR_W-1:0] ONE_STEP = ADDR_W'(1);

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |-> acc_addr == '0);

    assert_load_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && !strobe_n) |-> acc_addr == ext_addr);

    assert_step_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && strobe_n && !step_n) |-> acc_addr == last_addr + ONE_STEP);

    assert_keep_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && strobe_n && step_n) |=> $stable(last_addr));

    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && strobe_n && !step_n && (&last_addr)) |-> acc_addr == '0);

    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> last_addr == $past(acc_addr));
endmodule

bind burst_addr_ctr bac_checker #(.ADDR_W(ADDR_W)) u_bac_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_addr  (ext_addr),
    .strobe_n  (strobe_n),
    .step_n    (step_n),
    .clear_n   (clear_n),
    .acc_addr  (acc_addr),
    .last_addr (last_addr)
);

// File: tb/tb_burst_addr_ctr.sv
module tb_burst_addr_ctr;
    localparam int AW = 15;
    localparam logic [AW-1:0] TOP = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          strobe_n = 1'b1;
    logic          step_n = 1'b1;
    logic          clear_n = 1'b1;
    logic [AW-1:0] acc_addr;
    logic [AW-1:0] last_addr;

    int total = 0;
    int bad = 0;
    logic [AW-1:0] model_q = '0;
    bit done = 1'b0;

    burst_addr_ctr #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .strobe_n(strobe_n),
        .step_n(step_n), .clear_n(clear_n), .acc_addr(acc_addr), .last_addr(last_addr)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive after negedge, check acc_addr, then last_addr after the edge.
    task automatic cycle(input logic c, input logic s, input logic a,
                         input logic [AW-1:0] ext, input string req);
        logic [AW-1:0] exp_sel;
        @(negedge clk);
        clear_n = c; strobe_n = s; step_n = a; ext_addr = ext;
        if (!c)      exp_sel = '0;
        else if (!s) exp_sel = ext;
        else if (!a) exp_sel = model_q + AW'(1);
        else         exp_sel = model_q;
        #1;
        check(req, acc_addr, exp_sel);
        @(posedge clk); #2;
        model_q = exp_sel;
        check({req, "/R7"}, last_addr, model_q);
    endtask

    task automatic test_reset_R1();
        rst_n = 1'b0;
        @(negedge clk); strobe_n = 1'b0; ext_addr = 15'h1234;
        @(posedge clk); #2;
        check("R1", last_addr, '0);
        @(negedge clk); rst_n = 1'b1; strobe_n = 1'b1;
        model_q = '0;
    endtask

    task automatic test_load_R3();
        cycle(1, 0, 1, 15'h0abc, "R3");
        cycle(1, 0, 0, 15'h5555, "R3");   // load beats step
        cycle(1, 0, 1, 15'h7001, "R3");
    endtask

    task automatic test_step_R4();
        cycle(1, 1, 0, '0, "R4");
        cycle(1, 1, 0, 15'h3333, "R4");   // ext ignored
        cycle(1, 1, 0, '0, "R4");
    endtask

    task automatic test_keep_R5();
        cycle(1, 1, 1, 15'h2222, "R5");
        cycle(1, 1, 1, 15'h4444, "R5");
    endtask

    task automatic test_clear_R2();
        cycle(1, 0, 1, 15'h0777, "R3");
        cycle(0, 0, 0, 15'h1111, "R2");   // clear beats load and step
        cycle(0, 1, 1, 15'h1111, "R2");
        cycle(1, 1, 0, '0, "R4");
    endtask

    task automatic test_wrap_R6();
        cycle(1, 0, 1, TOP - AW'(1), "R3");
        cycle(1, 1, 0, '0, "R6");
        cycle(1, 1, 0, '0, "R6");
        check("R6", last_addr, '0);
    endtask

    task automatic test_edge_only_R8();
        cycle(1, 0, 1, 15'h0100, "R3");
        @(negedge clk);
        clear_n = 1'b1; strobe_n = 1'b1; step_n = 1'b1;
        #3 strobe_n = 1'b0; ext_addr = 15'h0999;
        #3 strobe_n = 1'b1; clear_n = 1'b0;
        #2 clear_n = 1'b1; step_n = 1'b0;
        #1 step_n = 1'b1;
        check("R8", last_addr, 15'h0100);
        @(posedge clk); #2;
        check("R8", last_addr, 15'h0100);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        test_reset_R1();
        test_load_R3();
        test_step_R4();
        test_keep_R5();
        test_clear_R2();
        test_wrap_R6();
        test_edge_only_R8();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule